// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the address for every access of a short burst. A load cycle captures a full external address. That address becomes the first beat, and the beat index returns to zero. Each later advance cycle keeps the upper address bits fixed and steps only the lowest bits. The low bits move through a four-word block in one of two wrap orders.

In linear order, the low bits count upward from the start value modulo four. In interleaved order, the low bits are the start value XORed with the beat index. The order is selected by a mode input and is captured when the burst is loaded. A clock enable freezes all state for as long as it is held low.

The address width and the burst length are parameters. The burst length must be a power of two.

Top module: `burst_addr_seq`

## Requirements
- R1: On a rising edge with `clk_en`=1 and `adv_ld`=0, `acc_addr` becomes `ext_addr` and `beat_idx` becomes 0 after that edge.
- R2: On a rising edge with `clk_en`=1 and `adv_ld`=1, `beat_idx` increments modulo 4, and bits [ADDR_W-1:2] of `acc_addr` are unchanged.
- R3: When the burst was loaded with `burst_mode`=0 (linear), `acc_addr[1:0]` = (start + `beat_idx`) mod 4. For example, a start of 01 gives 01, 10, 11, 00.
- R4: When the burst was loaded with `burst_mode`=1 (interleaved), `acc_addr[1:0]` = start XOR `beat_idx`. For example, a start of 01 gives 01, 00, 11, 10.
- R5: `burst_mode` is sampled only on load cycles. Changing it during advance cycles has no effect on the address order.
- R6: Advancing past the fourth beat wraps `beat_idx` to 0, and the low bits return to the start value, so the same four-beat pattern repeats.
- R7: While `clk_en`=0, `acc_addr` and `beat_idx` hold their values whatever `adv_ld`, `burst_mode` and `ext_addr` do.
- R8: While `rst_n`=0 and after its release, `acc_addr`=0 and `beat_idx`=0, and the captured order is linear. An advance without a prior load therefore steps linearly from address 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_en | input | 1 | Qualifies every edge; 0 holds all state |
| adv_ld | input | 1 | 0 loads `ext_addr`, 1 advances the burst |
| burst_mode | input | 1 | Order captured on load: 0 linear, 1 interleaved |
| ext_addr | input | ADDR_W (17) | Externally supplied start address |
| acc_addr | output | ADDR_W (17) | Address of the current beat |
| beat_idx | output | 2 | Beat number within the burst, 0 to 3 |

## Verification
The hardest case to reach from the ports is a burst that runs on past its fourth beat. That case must also toggle `burst_mode` and pause with `clk_en` low mid-burst, so that wrap, mode capture and hold all meet in one sequence. Directed sequences build exactly that: a load, more than four advances with the mode input flipped, and enable gaps placed inside the run. The random phase biases `adv_ld` toward advancing so that long wrapping bursts occur often.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;

  typedef enum logic {
    ORD_LINEAR     = 1'b0,
    ORD_INTERLEAVE = 1'b1
  } burst_order_e;

  // Linear position: start plus beat, wrapped inside the block
  function automatic int unsigned lin_pos(input int unsigned start,
                                          input int unsigned beat,
                                          input int unsigned len);
    return (start + beat) % len;
  endfunction

  // Interleaved position: start with beat bits flipped in
  function automatic int unsigned ilv_pos(input int unsigned start,
                                          input int unsigned beat);
    return start ^ beat;
  endfunction

endpackage

// File: rtl/burst_beat_ctr.sv
module burst_beat_ctr #(
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_evt,
  input  logic              step_evt,
  output logic [BEAT_W-1:0] beat
);

  localparam logic [BEAT_W-1:0] LAST = {BEAT_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        beat <= '0;
    else if (load_evt) beat <= '0;
    else if (step_evt) beat <= beat + 1'b1;
  end

  // R6
  wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && !load_evt && beat == LAST) |=> (beat == '0));

  // R1
  load_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (beat == '0));

endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg
  import burst_seq_pkg::*;
#(
  parameter int UPPER_W = 15,
  parameter int BEAT_W  = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_evt,
  input  logic [UPPER_W-1:0] upper_in,
  input  logic [BEAT_W-1:0]  low_in,
  input  logic               mode_in,
  output logic [UPPER_W-1:0] upper_q,
  output logic [BEAT_W-1:0]  start_q,
  output burst_order_e       mode_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      upper_q <= '0;
      start_q <= '0;
      mode_q  <= ORD_LINEAR;
    end else if (load_evt) begin
      upper_q <= upper_in;
      start_q <= low_in;
      mode_q  <= burst_order_e'(mode_in);
    end
  end

  // R5
  mode_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(mode_q));

  // R2
  upper_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !load_evt |=> $stable(upper_q));

endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen
  import burst_seq_pkg::*;
#(
  parameter int BEAT_W = 2
) (
  input  logic [BEAT_W-1:0] start_low,
  input  logic [BEAT_W-1:0] beat,
  input  burst_order_e      mode,
  output logic [BEAT_W-1:0] low_out
);

  localparam int unsigned LEN = 1 << BEAT_W;

  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = BEAT_W'(lin_pos(int'(start_low), int'(beat), LEN));
  assign ilv_low = BEAT_W'(ilv_pos(int'(start_low), int'(beat)));

  always_comb begin
    case (mode)
      ORD_INTERLEAVE: low_out = ilv_low;
      default:        low_out = lin_low;
    endcase
  end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int ADDR_W    = 17,
  parameter int BURST_LEN = 4
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        clk_en,
  input  logic                        adv_ld,
  input  logic                        burst_mode,
  input  logic [ADDR_W-1:0]           ext_addr,
  output logic [ADDR_W-1:0]           acc_addr,
  output logic [$clog2(BURST_LEN)-1:0] beat_idx
);

  localparam int BEAT_W  = $clog2(BURST_LEN);
  localparam int UPPER_W = ADDR_W - BEAT_W;

  initial begin
    len_pow2_chk: assert ((1 << BEAT_W) == BURST_LEN && BEAT_W > 0 && UPPER_W > 0);
  end

  // Named internal events
  logic load_evt;
  logic step_evt;
  assign load_evt = clk_en & ~adv_ld;
  assign step_evt = clk_en &  adv_ld;

  logic [UPPER_W-1:0] upper_q;
  logic [BEAT_W-1:0]  start_q;
  burst_order_e       mode_q;
  logic [BEAT_W-1:0]  beat_q;
  logic [BEAT_W-1:0]  acc_low;

  burst_addr_reg #(.UPPER_W(UPPER_W), .BEAT_W(BEAT_W)) u_areg (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .upper_in (ext_addr[ADDR_W-1:BEAT_W]),
    .low_in   (ext_addr[BEAT_W-1:0]),
    .mode_in  (burst_mode),
    .upper_q  (upper_q),
    .start_q  (start_q),
    .mode_q   (mode_q)
  );

  burst_beat_ctr #(.BEAT_W(BEAT_W)) u_beat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load_evt (load_evt),
    .step_evt (step_evt),
    .beat     (beat_q)
  );

  burst_order_gen #(.BEAT_W(BEAT_W)) u_order (
    .start_low (start_q),
    .beat      (beat_q),
    .mode      (mode_q),
    .low_out   (acc_low)
  );

  assign acc_addr = {upper_q, acc_low};
  assign beat_idx = beat_q;

  // R1
  load_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_evt |=> (acc_addr == $past(ext_addr) && beat_idx == '0));

  // R2
  beat_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    step_evt |=> (beat_idx == BEAT_W'($past(beat_idx) + 1'b1)));

  // R3
  linear_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_q == ORD_LINEAR) |=> (acc_low == BEAT_W'($past(acc_low) + 1'b1)));

  // R4
  ilv_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step_evt && mode_q == ORD_INTERLEAVE) |=>
      ((acc_low ^ $past(acc_low)) == (beat_idx ^ $past(beat_idx))));

  // R7
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_en |=> ($stable(acc_addr) && $stable(beat_idx)));

  // R8
  reset_val_chk: assert property (@(posedge clk)
    !rst_n |-> (acc_addr == '0 && beat_idx == '0));

endmodule

// File: tb/test_burst_addr_seq.sv
module test_burst_addr_seq;

  localparam int AW = 17;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          clk_en = 1'b0;
  logic          adv_ld = 1'b0;
  logic          burst_mode = 1'b0;
  logic [AW-1:0] ext_addr = '0;
  logic [AW-1:0] acc_addr;
  logic [1:0]    beat_idx;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model state
  logic [AW-1:0] m_base = '0;
  int            m_beat = 0;
  bit            m_ilv  = 1'b0;

  always #4 clk = ~clk;

  burst_addr_seq #(.ADDR_W(AW), .BURST_LEN(4)) i_burst_addr_seq (
    .clk(clk), .rst_n(rst_n), .clk_en(clk_en), .adv_ld(adv_ld),
    .burst_mode(burst_mode), .ext_addr(ext_addr),
    .acc_addr(acc_addr), .beat_idx(beat_idx)
  );

  // Expected low bits, written as explicit orders
  function automatic logic [1:0] exp_low(input logic [1:0] s, input int b, input bit ilv);
    logic [1:0] lin_tab [4];
    logic [1:0] r;
    lin_tab[0] = s; lin_tab[1] = s + 2'd1; lin_tab[2] = s + 2'd2; lin_tab[3] = s + 2'd3;
    if (!ilv) r = lin_tab[b % 4];
    else begin
      r = s;
      if (b[0]) r[0] = ~r[0];
      if (b[1]) r[1] = ~r[1];
    end
    return r;
  endfunction

  function automatic logic [AW-1:0] exp_addr();
    return {m_base[AW-1:2], exp_low(m_base[1:0], m_beat, m_ilv)};
  endfunction

  task automatic check(input string req, input logic [AW-1:0] ea, input int eb);
    checks++;
    if (acc_addr !== ea || beat_idx !== 2'(eb)) begin
      fails++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               req, acc_addr, beat_idx, ea, eb);
    end
  endtask

  // One cycle: drive at negedge, model the edge, compare at next negedge
  task automatic step(input bit ce, input bit adv, input bit md,
                      input logic [AW-1:0] a, input string req);
    clk_en = ce; adv_ld = adv; burst_mode = md; ext_addr = a;
    @(posedge clk);
    if (ce && !adv) begin m_base = a; m_beat = 0; m_ilv = md; end
    else if (ce) m_beat = (m_beat + 1) % 4;
    @(negedge clk);
    check(req, exp_addr(), m_beat);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    check("R8 reset", '0, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 after release", '0, 0);
    // R8: advance without load steps linearly from zero
    step(1, 1, 1, 17'h1ffff, "R8 advance from reset");
    step(1, 1, 0, '0, "R8 advance from reset");

    // R1 load then R3 linear from start 01: 01,10,11,00
    step(1, 0, 0, 17'h0a5a1, "R1 load");
    checks++; if (acc_addr[1:0] !== 2'b01) begin fails++; $display("FAIL R1: low=%b expected 01", acc_addr[1:0]); end
    step(1, 1, 0, '0, "R3 linear beat1");
    checks++; if (acc_addr !== 17'h0a5a2) begin fails++; $display("FAIL R3: %h expected 0a5a2", acc_addr); end
    step(1, 1, 0, '0, "R3 linear beat2");
    step(1, 1, 0, '0, "R3 linear beat3");
    checks++; if (acc_addr !== 17'h0a5a0) begin fails++; $display("FAIL R3: %h expected 0a5a0", acc_addr); end
    // R6 wrap back to start
    step(1, 1, 0, '0, "R6 wrap");
    checks++; if (acc_addr !== 17'h0a5a1 || beat_idx !== 2'd0) begin fails++; $display("FAIL R6: %h/%0d expected 0a5a1/0", acc_addr, beat_idx); end

    // R4 interleaved from start 01: 01,00,11,10, with R5 mode flips
    step(1, 0, 1, 17'h13335, "R1 load ilv");
    step(1, 1, 0, '0, "R5 R4 ilv beat1");
    checks++; if (acc_addr[1:0] !== 2'b00) begin fails++; $display("FAIL R4: low=%b expected 00", acc_addr[1:0]); end
    step(1, 1, 1, '0, "R4 ilv beat2");
    checks++; if (acc_addr[1:0] !== 2'b11) begin fails++; $display("FAIL R4: low=%b expected 11", acc_addr[1:0]); end
    // R7 hold with noisy inputs mid-burst
    step(0, 0, 0, 17'h00000, "R7 hold");
    step(0, 1, 1, 17'h1ffff, "R7 hold");
    step(1, 1, 0, '0, "R4 ilv beat3");
    checks++; if (acc_addr[1:0] !== 2'b10) begin fails++; $display("FAIL R4: low=%b expected 10", acc_addr[1:0]); end
    step(1, 1, 0, '0, "R6 ilv wrap");
    step(1, 1, 0, '0, "R6 ilv repeat");
    checks++; if (acc_addr !== 17'h13334 || beat_idx !== 2'd1) begin fails++; $display("FAIL R6: %h/%0d expected 13334/1", acc_addr, beat_idx); end

    // Random phase, biased toward advancing
    for (int i = 0; i < 600; i++) begin
      bit ce, adv, md;
      logic [AW-1:0] a;
      ce  = ($urandom % 8) != 0;
      adv = ($urandom % 5) != 0;
      md  = $urandom % 2;
      a   = AW'($urandom);
      step(ce, adv, md, a, !ce ? "R7 rand" : (!adv ? "R1 rand" : (m_ilv ? "R4 rand" : "R3 rand")));
    end

    // R2 upper bits stay put across a long advance run
    step(1, 0, 1, 17'h1c002, "R1 load");
    for (int i = 0; i < 9; i++) begin
      step(1, 1, ~burst_mode, '0, "R2 advance");
      checks++;
      if (acc_addr[AW-1:2] !== 15'(17'h1c002 >> 2)) begin
        fails++; $display("FAIL R2: upper=%h expected %h", acc_addr[AW-1:2], 15'(17'h1c002 >> 2));
      end
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule